// File: doc/BRIEF.md
# Camera Register Initialisation I2C Master

This block programs a camera sensor over a two-wire I2C bus as soon as the sensor is let out of reset, with no host behind it. It watches an external reset input. When that input goes from high to low, the block holds its own camera reset output for a set number of clock cycles. It then writes three fixed register values to the sensor.

Each table entry is a complete write transaction of its own. The transaction is a START, the device address byte with the write bit clear, the register address and the data byte, each byte followed by an acknowledge slot, and then a STOP. Every quarter of an SCL bit period is timed by a parameterised divider of the system clock. SDA is open drain: the block only ever pulls the line low or lets it go.

If the sensor fails to acknowledge any byte, the block ends that transaction with a STOP and raises a sticky error. It starts no further transaction. After the last STOP of a clean run, a sticky done flag rises.

Top module: `cam_reg_init`

## Requirements
- R1: Until a high-to-low change of `ext_rst_i` has been seen after `rst`, SCL stays high, SDA is released (`sda_oe_o` = 0), no START appears and `busy_o`, `done_o` and `err_o` are 0. Holding `ext_rst_i` low through and after `rst` does not count as such a change.
- R2: `cam_rst_o` is 1 from `rst` until between CAM_RST_CYC and CAM_RST_CYC+4 clock cycles after `ext_rst_i` falls, and then 0. While it is 1 the bus stays idle.
- R3: A START is SDA going low while SCL is high, followed by SCL going low. A STOP is SCL going high while SDA is low, followed by SDA going high.
- R4: Each transaction carries exactly three bytes, MSB first, sampled on the rising SCL edge: byte 0x40 (7-bit device address 0x20 with bit 0 = 0 for write), then the register address, then the data. Each byte is followed by a ninth SCL pulse during which the master releases SDA.
- R5: The transactions come in this order: register 0x15 with data 0x00, register 0x17 with data 0x41, register 0x3A with data 0x16. Each one ends with a STOP before the next START, and no repeated START is used.
- R6: Inside a transaction, SDA changes only while SCL is low, apart from the START and STOP edges. A clean run therefore shows exactly three STARTs and three STOPs.
- R7: An SDA level sampled high in an acknowledge slot ends the transaction with a STOP and sets `err_o`, which stays 1. No further START follows and `done_o` stays 0.
- R8: `done_o` goes to 1 after the third STOP and stays 1. `busy_o` is 1 from before the first START until `done_o` or `err_o` rises, and is never 1 together with either of them.
- R9: Every SCL high time within a byte lasts exactly 2*QTR_DIV clock cycles (one bit period is four quarters of QTR_DIV cycles each).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_rst_i | input | 1 | External reset; its falling edge starts the sequence |
| sda_i | input | 1 | Sampled level of the SDA line |
| scl_o | output | 1 | SCL line level |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| cam_rst_o | output | 1 | Camera reset, active high |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | All entries written (sticky) |
| err_o | output | 1 | An acknowledge was missing (sticky) |

## Verification
A bus-level sensor model decodes START, STOP, bits and acknowledges from the wire levels and compares the nine captured bytes against the expected table. A design that sends LSB first, changes SDA while SCL is high, or uses a repeated START in place of a STOP would show wrong bytes or extra START/STOP events. A second run has the model withhold the acknowledge for the first byte of the second transaction. It checks that the master had released SDA, that it stopped after exactly two transactions, and that error and done stay apart. A third run holds the external reset low across the system reset, which a design that mistakes a steady low level for an edge would treat as a start.

// File: rtl/cin_pkg.sv
`timescale 1ns/1ps
package cin_pkg;

  typedef enum logic [1:0] {F_IDLE, F_START, F_BITS, F_STOP} frame_st_t;

  typedef enum logic [2:0] {Q_WAIT, Q_CAMRST, Q_LAUNCH, Q_RUN, Q_DONE, Q_ERR} seq_st_t;

  localparam int unsigned N_ENTRIES   = 3;
  localparam int unsigned BYTES_PER_TX = 3;

  // {register address, data} for table entry i
  function automatic logic [15:0] init_entry(input int unsigned i);
    case (i)
      0:       init_entry = 16'h1500;
      1:       init_entry = 16'h1741;
      default: init_entry = 16'h3A16;
    endcase
  endfunction

endpackage

// File: rtl/cin_sync.sv
`timescale 1ns/1ps
module cin_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= {STAGES{RST_VAL}};
    else     chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/cin_qtick.sv
`timescale 1ns/1ps
module cin_qtick #(
  parameter int unsigned DIV = 250
) (
  input  logic clk,
  input  logic rst,
  input  logic en_i,
  output logic tick_o
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    tick_o <= 1'b0;
    if (rst || !en_i) begin
      cnt_q <= '0;
    end else if (cnt_q == LAST) begin
      cnt_q  <= '0;
      tick_o <= 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // quarter ticks are never back to back
  assert_tick_gap_R9: assert property (@(posedge clk) disable iff (rst)
    tick_o |=> !tick_o);
endmodule

// File: rtl/cin_frame.sv
`timescale 1ns/1ps
module cin_frame
  import cin_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       tick_i,
  input  logic       go_i,
  input  logic [7:0] dev_byte_i,
  input  logic [7:0] reg_byte_i,
  input  logic [7:0] dat_byte_i,
  input  logic       sda_i,
  output logic       active_o,
  output logic       scl_o,
  output logic       sda_oe_o,
  output logic       fin_o,
  output logic       fin_nack_o
);
  localparam logic [3:0] ACK_POS   = 4'd8;
  localparam logic [1:0] LAST_BYTE = 2'(BYTES_PER_TX - 1);

  frame_st_t  st_q;
  logic [1:0] phase_q;
  logic [3:0] bit_q;
  logic [1:0] byte_q;
  logic [7:0] sr_q;
  logic [7:0] bytes_q [BYTES_PER_TX];
  logic       scl_q, oe_q, nack_q;

  always_ff @(posedge clk) begin
    fin_o <= 1'b0;
    if (rst) begin
      st_q    <= F_IDLE;
      phase_q <= '0;
      bit_q   <= '0;
      byte_q  <= '0;
      sr_q    <= '0;
      scl_q   <= 1'b1;
      oe_q    <= 1'b0;
      nack_q  <= 1'b0;
      for (int i = 0; i < BYTES_PER_TX; i++) bytes_q[i] <= '0;
    end else if (st_q == F_IDLE) begin
      if (go_i) begin
        st_q       <= F_START;
        phase_q    <= '0;
        bytes_q[0] <= dev_byte_i;
        bytes_q[1] <= reg_byte_i;
        bytes_q[2] <= dat_byte_i;
        sr_q       <= dev_byte_i;
        nack_q     <= 1'b0;
      end
    end else if (tick_i) begin
      phase_q <= phase_q + 2'd1;
      case (st_q)
        F_START: begin
          case (phase_q)
            2'd0: oe_q  <= 1'b1;           // SDA falls, SCL high
            2'd2: scl_q <= 1'b0;           // then SCL falls
            2'd3: begin
              st_q   <= F_BITS;
              bit_q  <= '0;
              byte_q <= '0;
            end
            default: ;
          endcase
        end
        F_BITS: begin
          case (phase_q)
            2'd0: oe_q  <= (bit_q == ACK_POS) ? 1'b0 : ~sr_q[7];
            2'd1: scl_q <= 1'b1;
            2'd3: begin
              scl_q <= 1'b0;
              if (bit_q == ACK_POS) begin
                bit_q <= '0;
                if (sda_i || byte_q == LAST_BYTE) begin
                  st_q   <= F_STOP;
                  nack_q <= sda_i;
                end else begin
                  byte_q <= byte_q + 2'd1;
                  sr_q   <= bytes_q[byte_q + 2'd1];
                end
              end else begin
                bit_q <= bit_q + 4'd1;
                sr_q  <= {sr_q[6:0], 1'b0};
              end
            end
            default: ;
          endcase
        end
        F_STOP: begin
          case (phase_q)
            2'd0: oe_q  <= 1'b1;           // SDA low while SCL low
            2'd1: scl_q <= 1'b1;           // SCL rises first
            2'd2: oe_q  <= 1'b0;           // then SDA rises
            2'd3: begin
              st_q  <= F_IDLE;
              fin_o <= 1'b1;
            end
            default: ;
          endcase
        end
        default: st_q <= F_IDLE;
      endcase
    end
  end

  assign active_o   = (st_q != F_IDLE);
  assign scl_o      = scl_q;
  assign sda_oe_o   = oe_q;
  assign fin_nack_o = nack_q;

  // data held while SCL high within a bit
  assert_sda_stable_R6: assert property (@(posedge clk) disable iff (rst)
    (st_q == F_BITS && $past(st_q) == F_BITS && scl_q && $past(scl_q)) |-> $stable(oe_q));

  // acknowledge slot: master lets go of SDA
  assert_ack_release_R4: assert property (@(posedge clk) disable iff (rst)
    (st_q == F_BITS && bit_q == ACK_POS && phase_q != 2'd0) |-> !oe_q);

  // idle bus is released
  assert_idle_bus_R1: assert property (@(posedge clk) disable iff (rst)
    (st_q == F_IDLE && $past(st_q) == F_IDLE) |-> (scl_q && !oe_q));
endmodule

// File: rtl/cam_reg_init.sv
`timescale 1ns/1ps
module cam_reg_init
  import cin_pkg::*;
#(
  parameter int unsigned QTR_DIV     = 250,
  parameter int unsigned CAM_RST_CYC = 1000,
  parameter logic [6:0]  DEV_ADDR    = 7'h20
) (
  input  logic clk,
  input  logic rst,
  input  logic ext_rst_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_oe_o,
  output logic cam_rst_o,
  output logic busy_o,
  output logic done_o,
  output logic err_o
);
  localparam int unsigned CNTW = (CAM_RST_CYC > 1) ? $clog2(CAM_RST_CYC) : 1;
  localparam logic [CNTW-1:0] CNT_LAST = CNTW'(CAM_RST_CYC - 1);
  localparam int unsigned IDXW = $clog2(N_ENTRIES);
  localparam logic [IDXW-1:0] IDX_LAST = IDXW'(N_ENTRIES - 1);
  localparam logic [7:0] DEV_WR = {DEV_ADDR, 1'b0};

  logic ext_s, ext_prev_q, sda_s;
  logic tick, f_active, f_fin, f_nack, go_q;
  logic [15:0] entry;
  seq_st_t seq_q;
  logic [CNTW-1:0] cnt_q;
  logic [IDXW-1:0] idx_q;

  cin_sync #(.STAGES(2), .RST_VAL(1'b0)) i_ext_sync (
    .clk(clk), .rst(rst), .d_i(ext_rst_i), .q_o(ext_s));

  cin_sync #(.STAGES(2), .RST_VAL(1'b1)) i_sda_sync (
    .clk(clk), .rst(rst), .d_i(sda_i), .q_o(sda_s));

  cin_qtick #(.DIV(QTR_DIV)) i_qtick (
    .clk(clk), .rst(rst), .en_i(f_active), .tick_o(tick));

  assign entry = init_entry(int'(idx_q));

  cin_frame i_frame (
    .clk(clk), .rst(rst), .tick_i(tick), .go_i(go_q),
    .dev_byte_i(DEV_WR), .reg_byte_i(entry[15:8]), .dat_byte_i(entry[7:0]),
    .sda_i(sda_s), .active_o(f_active), .scl_o(scl_o), .sda_oe_o(sda_oe_o),
    .fin_o(f_fin), .fin_nack_o(f_nack));

  always_ff @(posedge clk) begin
    go_q <= 1'b0;
    if (rst) begin
      seq_q      <= Q_WAIT;
      ext_prev_q <= 1'b0;
      cnt_q      <= '0;
      idx_q      <= '0;
      cam_rst_o  <= 1'b1;
      busy_o     <= 1'b0;
      done_o     <= 1'b0;
      err_o      <= 1'b0;
    end else begin
      ext_prev_q <= ext_s;
      case (seq_q)
        Q_WAIT: begin
          if (ext_prev_q && !ext_s) begin
            seq_q <= Q_CAMRST;
            cnt_q <= '0;
          end
        end
        Q_CAMRST: begin
          if (cnt_q == CNT_LAST) begin
            cam_rst_o <= 1'b0;
            idx_q     <= '0;
            seq_q     <= Q_LAUNCH;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        Q_LAUNCH: begin
          go_q   <= 1'b1;
          busy_o <= 1'b1;
          seq_q  <= Q_RUN;
        end
        Q_RUN: begin
          if (f_fin) begin
            if (f_nack) begin
              err_o  <= 1'b1;
              busy_o <= 1'b0;
              seq_q  <= Q_ERR;
            end else if (idx_q == IDX_LAST) begin
              done_o <= 1'b1;
              busy_o <= 1'b0;
              seq_q  <= Q_DONE;
            end else begin
              idx_q <= idx_q + 1'b1;
              seq_q <= Q_LAUNCH;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assert_bus_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    cam_rst_o |-> (scl_o && !sda_oe_o && !f_active));

  assert_no_restart_R7: assert property (@(posedge clk) disable iff (rst)
    err_o |-> (!f_active && !done_o));

  assert_done_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    done_o |=> done_o);

  assert_busy_excl_R8: assert property (@(posedge clk) disable iff (rst)
    busy_o |-> !(done_o || err_o));
endmodule

// File: tb/test_cam_reg_init.sv
`timescale 1ns/1ps
module test_cam_reg_init;
  localparam int unsigned QTR = 4;
  localparam int unsigned CAMC = 20;
  localparam int unsigned NEXP = 9;
  localparam logic [7:0] EXP [NEXP] = '{8'h40, 8'h15, 8'h00,
                                        8'h40, 8'h17, 8'h41,
                                        8'h40, 8'h3A, 8'h16};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ext_rst = 1'b1;
  logic scl, oe, cam_rst, busy, done, err;
  logic slave_pull = 1'b0;
  wire  sda_line = !(oe || slave_pull);

  always #2.5 clk = ~clk;

  cam_reg_init #(.QTR_DIV(QTR), .CAM_RST_CYC(CAMC), .DEV_ADDR(7'h20)) i_cam_reg_init (
    .clk(clk), .rst(rst), .ext_rst_i(ext_rst), .sda_i(sda_line),
    .scl_o(scl), .sda_oe_o(oe), .cam_rst_o(cam_rst),
    .busy_o(busy), .done_o(done), .err_o(err));

  int nchk = 0, nerr = 0;
  bit finished = 0;

  // bus monitor / sensor model
  int nstarts, nstops, bad_tx, tx_bytes, bitc, nbytes, nack_at;
  bit in_tx;
  logic [7:0] shreg;
  logic [7:0] cap [16];
  logic ackv [16];
  longint hi_t, hmin, hmax;

  always @(negedge sda_line) if (scl === 1'b1) begin
    if (in_tx) bad_tx++;
    in_tx = 1; nstarts++; bitc = 0; tx_bytes = 0;
  end

  always @(posedge sda_line) if (scl === 1'b1 && in_tx) begin
    nstops++;
    if (tx_bytes != 3) bad_tx++;
    in_tx = 0;
  end

  always @(posedge scl) if (in_tx) begin
    hi_t = longint'($time);
    if (bitc % 9 < 8) begin
      shreg = {shreg[6:0], sda_line};
      if (bitc % 9 == 7 && nbytes < 16) begin
        cap[nbytes] = shreg; nbytes++; tx_bytes++;
      end
    end else if (nbytes > 0 && nbytes <= 16) begin
      ackv[nbytes-1] = sda_line;
    end
    bitc++;
  end

  always @(negedge scl) begin
    if (in_tx && bitc > 0) begin
      if (longint'($time) - hi_t < hmin) hmin = longint'($time) - hi_t;
      if (longint'($time) - hi_t > hmax) hmax = longint'($time) - hi_t;
    end
    if (in_tx && bitc > 0 && bitc % 9 == 8) slave_pull = ((nbytes - 1) != nack_at);
    else slave_pull = 0;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_mon(input int nack_idx);
    nstarts = 0; nstops = 0; bad_tx = 0; tx_bytes = 0; bitc = 0; nbytes = 0;
    in_tx = 0; nack_at = nack_idx; hmin = 64'h7fffffff; hmax = 0;
    for (int i = 0; i < 16; i++) begin cap[i] = 8'hxx; ackv[i] = 1'bx; end
  endtask

  task automatic do_reset(input logic ext_level);
    @(negedge clk); rst = 1; ext_rst = ext_level;
    repeat (5) @(negedge clk);
    clear_mon(99);
    rst = 0;
    @(negedge clk);
  endtask

  task automatic wait_end(input int lim);
    for (int i = 0; i < lim; i++) begin
      @(negedge clk);
      if (done || err) break;
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      nchk++; nerr++;
      $display("FAIL R8 watchdog expired actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    int fall_cyc;
    // ---------------- clean run ----------------
    do_reset(1'b1);
    chk("R1 scl idle", scl, 1);
    chk("R1 sda idle", sda_line, 1);
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 err", err, 0);
    chk("R2 cam_rst at reset", cam_rst, 1);
    repeat (60) @(negedge clk);
    chk("R1 no start while ext high", nstarts, 0);
    chk("R2 cam_rst while ext high", cam_rst, 1);
    ext_rst = 0;
    fall_cyc = 0;
    for (int i = 0; i < CAMC + 10; i++) begin
      @(negedge clk);
      if (!cam_rst) break;
      fall_cyc++;
      if (scl !== 1'b1 || sda_line !== 1'b1) begin
        chk("R2 bus quiet during cam reset", {scl, sda_line}, 2'b11);
      end
    end
    chk("R2 cam_rst release window", (fall_cyc >= CAMC - 1 && fall_cyc <= CAMC + 4), 1);
    chk("R2 no start before release", nstarts, 0);
    for (int i = 0; i < 2000 && nstarts == 0; i++) @(negedge clk);
    chk("R8 busy after first start", busy, 1);
    wait_end(20000);
    chk("R8 done", done, 1);
    chk("R8 busy cleared", busy, 0);
    chk("R7 no err", err, 0);
    // expected-byte table walk
    for (int i = 0; i < NEXP; i++) begin
      chk($sformatf("R4 R5 byte %0d", i), cap[i], EXP[i]);
      chk($sformatf("R4 ack slot %0d", i), ackv[i], 0);
    end
    chk("R4 byte count", nbytes, NEXP);
    chk("R5 starts", nstarts, 3);
    chk("R5 stops", nstops, 3);
    chk("R6 framing errors", bad_tx, 0);
    chk("R3 bus released after stop", {scl, sda_line}, 2'b11);
    chk("R9 scl high min", hmin, 2 * QTR * 5);
    chk("R9 scl high max", hmax, 2 * QTR * 5);
    repeat (300) @(negedge clk);
    chk("R8 done sticky", done, 1);
    chk("R6 no further start", nstarts, 3);

    // ---------------- nack on first byte of second transaction ----------------
    do_reset(1'b1);
    nack_at = 3;
    repeat (10) @(negedge clk);
    ext_rst = 0;
    wait_end(20000);
    chk("R7 err set", err, 1);
    chk("R7 done stays low", done, 0);
    chk("R8 busy low on err", busy, 0);
    chk("R7 stop issued", nstops, 2);
    chk("R4 master released in ack", ackv[3], 1);
    chk("R4 nacked byte", cap[3], 8'h40);
    repeat (2000) @(negedge clk);
    chk("R7 no further start", nstarts, 2);
    chk("R7 err sticky", err, 1);
    chk("R3 bus released after nack stop", {scl, sda_line}, 2'b11);

    // ---------------- ext reset low throughout reset ----------------
    do_reset(1'b0);
    repeat (1500) @(negedge clk);
    chk("R1 steady low is not an edge", nstarts, 0);
    chk("R2 cam_rst held without edge", cam_rst, 1);
    chk("R1 busy without edge", busy, 0);
    ext_rst = 1;
    repeat (10) @(negedge clk);
    ext_rst = 0;
    wait_end(20000);
    chk("R5 run after real edge", done, 1);
    chk("R5 three transactions", nstops, 3);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule